// File: doc/BRIEF.md
# Match-Compare Operating-System Timer

This block is a 32-bit system timer that software programs through a small word-addressed register window. Writing a target value into the match register starts a single count toward that target, measured from the counter value stored at the last expiry. The distance wraps through the top of the 32-bit range when the target is not above the stored counter. While the count runs, reading the counter register shows a value that rises toward the target, one step per enabled tick.

When the count completes, the stored counter takes the target value and the timer goes idle until the next match write. If the interrupt-enable register holds any nonzero value at that moment, a status flag is set and a registered level interrupt goes high. The interrupt stays high until software writes the status register. A `tick_en` input gates every counting step, so a single clock domain can run the timer at a slower tick rate.

Top module: `ostm_timer`

## Requirements
- R1: After reset the match, counter, status and interrupt-enable registers all read as zero, `irq` is low and the timer is idle.
- R2: The interrupt-enable register at byte offset 0x1C reads back the last value written to it. The match register at offset 0x00 always reads zero.
- R3: A match write of value M when the stored counter is C loads a count length of M − C if M > C. Otherwise the length is M + (0xFFFFFFFF − C) modulo 2^32, so M equal to C gives 0xFFFFFFFF.
- R4: While counting, the counter register at offset 0x10 reads M minus the remaining length. The remaining length falls by one on each clock edge with `tick_en` high and holds when `tick_en` is low.
- R5: On the enabled edge that uses up the length, the stored counter becomes M and counting stops. From then until the next match write, the counter register reads M.
- R6: At expiry with a nonzero interrupt-enable value, status (offset 0x14, bit 0) becomes 1 and `irq` rises on that same edge and stays high. With the enable at zero, status and `irq` do not change.
- R7: A write to the status register while status is 1 clears status, and `irq` is low after that edge.
- R8: A match write on the same edge as an expiry wins. No expiry takes effect, status and `irq` stay unchanged, the stored counter keeps its old value, and a new count starts.
- R9: A status write on the same edge as an interrupting expiry loses. Status and `irq` are 1 after that edge.
- R10: Unmapped offsets and offsets with nonzero bits [1:0] read as zero, and writes to them change no register.
- R11: A match write while a count is already running restarts the count. The new length is computed from the stored counter, not from the value the counter register shows at that moment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Counting step enable for this clock |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | ADDR_W | Byte offset for reads and writes |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt, registered |

## Verification
Reads are combinational, so a read value is due in the same cycle its address is presented. Every register write takes effect on the edge that samples the strobe. An interrupting expiry shows on `irq` exactly L enabled ticks after the match-write edge. The bench counts edges from the write edge, or from the cycle `tick_en` is re-raised, and queues each expected item with the cycle number it is due in. The monitor compares only at that cycle, half a period after the driving edge. The priority cases are set up by issuing the second write in the cycle that lines its sampling edge up with the computed expiry edge.

// File: rtl/ostm_pkg.sv
`timescale 1ns/1ps
package ostm_pkg;

   // byte offsets of the register window
   localparam int unsigned OFF_MATCH = 32'h00;
   localparam int unsigned OFF_COUNT = 32'h10;
   localparam int unsigned OFF_STAT  = 32'h14;
   localparam int unsigned OFF_IEN   = 32'h1C;

   typedef enum logic [2:0] {
      REG_NONE,
      REG_MATCH,
      REG_COUNT,
      REG_STAT,
      REG_IEN
   } reg_sel_e;

endpackage

// File: rtl/ostm_decode.sv
`timescale 1ns/1ps
module ostm_decode #(
   parameter int ADDR_W      = 8,
   parameter bit ALIGN_CHECK = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   output ostm_pkg::reg_sel_e sel
);
   import ostm_pkg::*;

   localparam int WORD_W = ADDR_W - 2;
   localparam logic [WORD_W-1:0] W_MATCH = WORD_W'(OFF_MATCH >> 2);
   localparam logic [WORD_W-1:0] W_COUNT = WORD_W'(OFF_COUNT >> 2);
   localparam logic [WORD_W-1:0] W_STAT  = WORD_W'(OFF_STAT  >> 2);
   localparam logic [WORD_W-1:0] W_IEN   = WORD_W'(OFF_IEN   >> 2);

   logic              aligned;
   logic [WORD_W-1:0] word;

   assign word = addr[ADDR_W-1:2];

   generate
      if (ALIGN_CHECK) begin : g_strict
         assign aligned = (addr[1:0] == 2'b00);
      end else begin : g_loose
         assign aligned = 1'b1;
      end
   endgenerate

   always_comb begin
      sel = REG_NONE;
      if (aligned) begin
         if (word == W_MATCH)      sel = REG_MATCH;
         else if (word == W_COUNT) sel = REG_COUNT;
         else if (word == W_STAT)  sel = REG_STAT;
         else if (word == W_IEN)   sel = REG_IEN;
      end
   end

endmodule

// File: rtl/ostm_count.sv
`timescale 1ns/1ps
module ostm_count #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              match_we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] match_q,
   output logic [DATA_W-1:0] snap_q,
   output logic [DATA_W-1:0] remain_q,
   output logic              running_q,
   output logic              expire
);
   localparam logic [DATA_W-1:0] ALL_ONES = '1;
   localparam logic [DATA_W-1:0] ONE      = DATA_W'(1);

   logic [DATA_W-1:0] span;

   // distance from the stored counter to the new target, wrapping at the top
   always_comb begin
      if (wdata > snap_q) span = wdata - snap_q;
      else                span = wdata + (ALL_ONES - snap_q);
   end

   // a match write in the same cycle suppresses the expiry
   assign expire = running_q && tick_en && !match_we && (remain_q <= ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         match_q   <= '0;
         snap_q    <= '0;
         remain_q  <= '0;
         running_q <= 1'b0;
      end else if (match_we) begin
         match_q   <= wdata;
         remain_q  <= span;
         running_q <= 1'b1;
      end else if (expire) begin
         snap_q    <= match_q;
         remain_q  <= '0;
         running_q <= 1'b0;
      end else if (running_q && tick_en) begin
         remain_q  <= remain_q - ONE;
      end
   end

endmodule

// File: rtl/ostm_irq.sv
`timescale 1ns/1ps
module ostm_irq #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ien_we,
   input  logic              stat_we,
   input  logic              expire,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] ien_q,
   output logic              status_q,
   output logic              irq
);
   logic status_d;

   // a new event outranks a clear in the same cycle
   always_comb begin
      status_d = status_q;
      if (expire && (ien_q != '0)) status_d = 1'b1;
      else if (stat_we)            status_d = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ien_q    <= '0;
         status_q <= 1'b0;
         irq      <= 1'b0;
      end else begin
         if (ien_we) ien_q <= wdata;
         status_q <= status_d;
         irq      <= status_d;
      end
   end

endmodule

// File: rtl/ostm_timer.sv
`timescale 1ns/1ps
module ostm_timer #(
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 8,
   parameter bit ALIGN_CHECK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);
   import ostm_pkg::*;

   generate
      if (DATA_W < 8 || DATA_W > 64) begin : g_bad_data_w
         $error("ostm_timer: DATA_W must lie in 8..64");
      end
      if (ADDR_W < 5 || ADDR_W > 16) begin : g_bad_addr_w
         $error("ostm_timer: ADDR_W must lie in 5..16");
      end
   endgenerate

   reg_sel_e          sel;
   logic              match_we;
   logic              stat_we;
   logic              ien_we;
   logic              expire;
   logic              running_q;
   logic              status_q;
   logic [DATA_W-1:0] match_q;
   logic [DATA_W-1:0] snap_q;
   logic [DATA_W-1:0] remain_q;
   logic [DATA_W-1:0] ien_q;
   logic [DATA_W-1:0] count_view;

   ostm_decode #(
      .ADDR_W      (ADDR_W),
      .ALIGN_CHECK (ALIGN_CHECK)
   ) u_decode (
      .addr (bus_addr),
      .sel  (sel)
   );

   assign match_we = bus_wr && (sel == REG_MATCH);
   assign stat_we  = bus_wr && (sel == REG_STAT);
   assign ien_we   = bus_wr && (sel == REG_IEN);

   ostm_count #(
      .DATA_W (DATA_W)
   ) u_count (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_en   (tick_en),
      .match_we  (match_we),
      .wdata     (bus_wdata),
      .match_q   (match_q),
      .snap_q    (snap_q),
      .remain_q  (remain_q),
      .running_q (running_q),
      .expire    (expire)
   );

   ostm_irq #(
      .DATA_W (DATA_W)
   ) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .ien_we   (ien_we),
      .stat_we  (stat_we),
      .expire   (expire),
      .wdata    (bus_wdata),
      .ien_q    (ien_q),
      .status_q (status_q),
      .irq      (irq)
   );

   // counter view climbs toward the target as the remainder drains
   assign count_view = match_q - remain_q;

   always_comb begin
      case (sel)
         REG_COUNT: bus_rdata = count_view;
         REG_STAT:  bus_rdata = {{(DATA_W-1){1'b0}}, status_q};
         REG_IEN:   bus_rdata = ien_q;
         default:   bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/ostm_timer_chk.sv
`timescale 1ns/1ps
module ostm_timer_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick_en,
   input logic              match_we,
   input logic              stat_we,
   input logic              expire,
   input logic              running_q,
   input logic              status_q,
   input logic              irq,
   input logic [DATA_W-1:0] remain_q,
   input logic [DATA_W-1:0] match_q,
   input logic [DATA_W-1:0] snap_q,
   input logic [DATA_W-1:0] ien_q
);
   p_irq_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(ien_q != '0));

   p_irq_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq && !stat_we |=> irq);

   p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      stat_we && status_q && !expire |=> !irq && !status_q);

   p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      expire && (ien_q != '0) |=> irq && status_q);

   p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      running_q && tick_en && !match_we && (remain_q > DATA_W'(1))
      |=> remain_q == $past(remain_q) - DATA_W'(1));

   p_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
      running_q && !tick_en && !match_we |=> $stable(remain_q) && running_q);

   p_snap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> (snap_q == $past(match_q)) && !running_q);

   p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !running_q && !match_we |=> !running_q && $stable(snap_q));

   p_write_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      match_we && !irq |=> !irq && running_q);

endmodule

bind ostm_timer ostm_timer_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick_en   (tick_en),
   .match_we  (match_we),
   .stat_we   (stat_we),
   .expire    (expire),
   .running_q (running_q),
   .status_q  (status_q),
   .irq       (irq),
   .remain_q  (remain_q),
   .match_q   (match_q),
   .snap_q    (snap_q),
   .ien_q     (ien_q)
);

// File: tb/ostm_timer_test.sv
`timescale 1ns/1ps
module ostm_timer_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b1;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = 8'h00;
   logic [31:0] bus_wdata = 32'h0;
   logic [31:0] bus_rdata;
   logic        irq;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   typedef struct {
      int          due;
      bit          is_irq;
      logic [31:0] val;
      logic [7:0]  addr;
      string       tag;
   } exp_t;

   exp_t q[$];

   // model state, kept from the requirements
   logic [31:0] m_snap = 32'h0;
   logic [31:0] m_match = 32'h0;
   logic [31:0] m_len = 32'h0;
   int          c_w = 0;

   ostm_timer uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_en   (tick_en),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq       (irq)
   );

   always #2.5 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   // monitor: compares every queued item in the cycle it is due
   always begin
      @(negedge clk);
      #1;
      for (int i = q.size() - 1; i >= 0; i--) begin
         if (q[i].due == cyc) begin
            logic [31:0] act;
            act = q[i].is_irq ? {31'b0, irq} : bus_rdata;
            checks++;
            if (act !== q[i].val) begin
               errors++;
               if (q[i].is_irq)
                  $display("FAIL %s irq cycle %0d actual %0h expected %0h",
                           q[i].tag, cyc, act, q[i].val);
               else
                  $display("FAIL %s read 0x%02h cycle %0d actual %0h expected %0h",
                           q[i].tag, q[i].addr, cyc, act, q[i].val);
            end
            q.delete(i);
         end
      end
   end

   function automatic logic [31:0] span_of(input logic [31:0] m, input logic [31:0] s);
      return (m > s) ? (m - s) : (m + (32'hFFFF_FFFF - s));
   endfunction

   // counter view at cycle t when every edge since the write was a tick
   function automatic logic [31:0] cnt_at(input int t);
      return m_match - (m_len - 32'(t - c_w));
   endfunction

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      bus_wr = 1'b1;
      bus_addr = a;
      bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
      bus_addr = a;
      q.push_back('{cyc, 1'b0, e, a, tag});
      @(negedge clk);
   endtask

   task automatic irq_at(input int t, input logic v, input string tag);
      q.push_back('{t, 1'b1, {31'b0, v}, 8'h00, tag});
   endtask

   task automatic wait_until(input int t);
      while (cyc < t) @(negedge clk);
   endtask

   task automatic arm(input logic [31:0] m);
      bus_write(8'h00, m);
      m_match = m;
      m_len = span_of(m, m_snap);
      c_w = cyc;
   endtask

   task automatic clear_status();
      bus_write(8'h14, 32'h0);
      irq_at(cyc, 1'b0, "R7");
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int t1;
      int ce;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      irq_at(cyc, 1'b0, "R1");
      rd(8'h10, 32'h0, "R1");
      rd(8'h14, 32'h0, "R1");
      rd(8'h1C, 32'h0, "R1");
      rd(8'h00, 32'h0, "R1");

      // R2: enable read-back, match write-only
      bus_write(8'h1C, 32'h0000_0001);
      rd(8'h1C, 32'h1, "R2");

      // R3 R4 R5 R6: first count of 10 from counter 0
      arm(32'd10);
      rd(8'h00, 32'h0, "R2");
      rd(8'h10, cnt_at(cyc), "R4");
      rd(8'h10, cnt_at(cyc), "R4");
      irq_at(c_w + 9, 1'b0, "R6");
      irq_at(c_w + 10, 1'b1, "R6");
      wait_until(c_w + 12);
      m_snap = 32'd10;
      rd(8'h10, 32'd10, "R5");
      rd(8'h14, 32'h1, "R6");
      irq_at(cyc, 1'b1, "R6");
      rd(8'h10, 32'd10, "R5");

      // R7: clear
      clear_status();
      rd(8'h14, 32'h0, "R7");

      // R4: tick_en low freezes the count
      tick_en = 1'b0;
      arm(32'd15);
      rd(8'h10, 32'd10, "R4");
      rd(8'h10, 32'd10, "R4");
      rd(8'h10, 32'd10, "R4");
      tick_en = 1'b1;
      t1 = cyc;
      irq_at(t1 + 4, 1'b0, "R4");
      irq_at(t1 + 5, 1'b1, "R4");
      wait_until(t1 + 7);
      m_snap = 32'd15;
      rd(8'h10, 32'd15, "R5");
      clear_status();

      // R3 wrap, then R11 restart from the stored counter
      arm(32'd3);
      rd(8'h10, cnt_at(cyc), "R3");
      rd(8'h10, cnt_at(cyc), "R3");
      arm(32'd20);
      irq_at(c_w + 4, 1'b0, "R11");
      irq_at(c_w + 5, 1'b1, "R11");
      wait_until(c_w + 6);
      m_snap = 32'd20;
      rd(8'h10, 32'd20, "R11");
      clear_status();

      // R3 equal target gives the full-range length
      arm(32'd20);
      rd(8'h10, 32'd21, "R3");
      rd(8'h10, 32'd22, "R3");
      arm(32'd25);
      irq_at(c_w + 5, 1'b1, "R3");
      wait_until(c_w + 6);
      m_snap = 32'd25;
      clear_status();

      // R6: enable zero, expiry raises nothing
      bus_write(8'h1C, 32'h0);
      arm(32'd30);
      irq_at(c_w + 5, 1'b0, "R6");
      wait_until(c_w + 7);
      m_snap = 32'd30;
      rd(8'h10, 32'd30, "R5");
      rd(8'h14, 32'h0, "R6");
      irq_at(cyc, 1'b0, "R6");
      bus_write(8'h1C, 32'h1);

      // R8: match write on the expiry edge
      arm(32'd33);
      ce = c_w;
      wait_until(ce + 2);
      arm(32'd40);
      irq_at(c_w, 1'b0, "R8");
      rd(8'h10, 32'd30, "R8");
      rd(8'h10, 32'd31, "R8");
      irq_at(c_w + 9, 1'b0, "R8");
      irq_at(c_w + 10, 1'b1, "R8");
      wait_until(c_w + 11);
      m_snap = 32'd40;
      rd(8'h14, 32'h1, "R8");

      // R9: status clear on the expiry edge loses
      arm(32'd44);
      ce = c_w;
      wait_until(ce + 3);
      bus_write(8'h14, 32'h0);
      irq_at(cyc, 1'b1, "R9");
      rd(8'h14, 32'h1, "R9");
      m_snap = 32'd44;
      clear_status();

      // R10: unmapped and misaligned offsets
      bus_write(8'h04, 32'hFFFF_FFFF);
      rd(8'h04, 32'h0, "R10");
      bus_write(8'h1D, 32'h0);
      rd(8'h1C, 32'h1, "R10");
      rd(8'h1D, 32'h0, "R10");
      bus_write(8'h18, 32'h7);
      rd(8'h18, 32'h0, "R10");
      rd(8'h10, 32'd44, "R10");
      rd(8'h14, 32'h0, "R10");
      irq_at(cyc, 1'b0, "R10");

      repeat (3) @(negedge clk);
      foreach (q[i]) begin
         errors++;
         $display("FAIL %s item due %0d never compared, actual none expected %0h",
                  q[i].tag, q[i].due, q[i].val);
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule